// File: doc/BRIEF.md
# Cell Routing Header Filter

This block sits on the receive side of a shared cell bus. It looks at the 16-bit routing header at the front of each arriving cell and decides whether the local unit keeps the cell. Each header comes in as one word with a valid strobe. The block does three things with it. It recomputes a 4-bit check over the upper twelve header bits and compares the result with the check field in the low nibble. It decodes the header into one of seven formats, which combine a route (broadcast, multicast or single-destination) with a kind (data, control or loopback). It then tests the destination: a single-destination cell must name this unit's configured address, and a multicast cell's net number must be enabled in a local table of per-net bits.

The decision comes out one clock after the header. It carries a valid flag, an accept bit, a check-error strobe and a 3-bit class code. A configuration port sets or clears single entries of the multicast table. The unit address is a static input.

Top module: `chf_hdr_filter`

## Requirements
- R1: The check field is hdr[3:0]. It must equal the remainder of hdr[15:4] under the generator x^4+x+1, computed MSB first from an all-zero start. When the two differ, crc_err_o is 1 and the cell is not accepted.
- R2: out_valid_o is 1 exactly one clock after each cycle with hdr_valid_i high, and 0 otherwise. Back-to-back headers produce back-to-back decisions. While out_valid_o is 0, accept_o, crc_err_o and cls_o are all 0.
- R3: Format decode and class codes. If hdr[15]=1 the cell is multicast, and hdr[14] selects control (code 4) or data (code 3). If hdr[15:14]=01 the cell is broadcast, and hdr[13] selects control (code 2) or data (code 1). If hdr[15:14]=00 the cell is single-destination, and hdr[13:12] selects 00 data (code 5), 01 control (code 6) or 10 loopback (code 7).
- R4: A broadcast cell with a good check field is always accepted.
- R5: A multicast cell with a good check field is accepted only when the table entry for its net number hdr[13:8] is set.
- R6: A single-destination cell with a good check field is accepted only when hdr[11:4] equals unit_addr_i.
- R7: A single-destination header with hdr[13:12]=11 is malformed. It reports class code 0 and is never accepted.
- R8: When cfg_we_i is high at a clock edge, the table entry at cfg_net_i takes the value cfg_en_i. The change applies to headers presented after that edge.
- R9: Reset (synchronous, active high) clears all outputs and every multicast table entry.
- R10: A check-field mismatch overrides routing. The cell is discarded even when its route would match, and cls_o still reports the decoded format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid_i | input | 1 | Header word present this cycle |
| hdr_i | input | 16 | Routing header word |
| unit_addr_i | input | 8 | This unit's address |
| cfg_we_i | input | 1 | Multicast table write strobe |
| cfg_net_i | input | 6 | Table entry to write |
| cfg_en_i | input | 1 | Value written to the entry |
| out_valid_o | output | 1 | Decision valid |
| accept_o | output | 1 | Cell is kept |
| crc_err_o | output | 1 | Check-field mismatch |
| cls_o | output | 3 | Class code (see R3, R7) |

## Verification
Every decision is due exactly one clock after its header is presented, because one register stage lies between hdr_i and the outputs. The driver stamps each expected result with that cycle number. The monitor samples on the falling edge, pops the head of the queue and checks that the stamp equals the current cycle. An output that arrives early, late or unexpected fails, and so does an expected item that is still waiting past its cycle. A table write goes in one clock before the header that depends on it, and the bench's table model is updated at the same point.

// File: rtl/chf_pkg.sv
`timescale 1ns/1ps
package chf_pkg;
  typedef enum logic [2:0] {
    CLS_NONE    = 3'd0,
    CLS_BC_DATA = 3'd1,
    CLS_BC_CTRL = 3'd2,
    CLS_MC_DATA = 3'd3,
    CLS_MC_CTRL = 3'd4,
    CLS_SD_DATA = 3'd5,
    CLS_SD_CTRL = 3'd6,
    CLS_SD_LOOP = 3'd7
  } cell_cls_e;

  typedef enum logic [1:0] {
    RT_SINGLE = 2'd0,
    RT_MCAST  = 2'd1,
    RT_BCAST  = 2'd2,
    RT_BAD    = 2'd3
  } route_e;
endpackage

// File: rtl/chf_crc4.sv
`timescale 1ns/1ps
// Parallel form of a bit-serial check-field generator, MSB first, zero start.
module chf_crc4 #(
  parameter int DATA_W = 12,
  parameter int CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'h3
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_comb begin
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ data_i[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    crc_o = r;
  end
endmodule

// File: rtl/chf_decode.sv
`timescale 1ns/1ps
// Format decode of the upper twelve header bits (hdr[15:4]).
module chf_decode
  import chf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NET_W  = 6
) (
  input  logic [11:0]       body_i,
  output route_e            route_o,
  output cell_cls_e         cls_o,
  output logic [ADDR_W-1:0] dest_o,
  output logic [NET_W-1:0]  net_o
);
  // body_i[11] is hdr[15]
  always_comb begin
    dest_o  = body_i[0 +: ADDR_W];
    net_o   = body_i[4 +: NET_W];
    route_o = RT_BAD;
    cls_o   = CLS_NONE;
    if (body_i[11]) begin
      route_o = RT_MCAST;
      cls_o   = body_i[10] ? CLS_MC_CTRL : CLS_MC_DATA;
    end else if (body_i[10]) begin
      route_o = RT_BCAST;
      cls_o   = body_i[9] ? CLS_BC_CTRL : CLS_BC_DATA;
    end else begin
      unique case (body_i[9:8])
        2'b00:   begin route_o = RT_SINGLE; cls_o = CLS_SD_DATA; end
        2'b01:   begin route_o = RT_SINGLE; cls_o = CLS_SD_CTRL; end
        2'b10:   begin route_o = RT_SINGLE; cls_o = CLS_SD_LOOP; end
        default: begin route_o = RT_BAD;    cls_o = CLS_NONE;    end
      endcase
    end
  end
endmodule

// File: rtl/chf_mcast_tbl.sv
`timescale 1ns/1ps
// Per-net enable bits, one write port, one asynchronous read port.
module chf_mcast_tbl #(
  parameter int NET_W = 6,
  localparam int DEPTH = 1 << NET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [NET_W-1:0] waddr_i,
  input  logic             wdata_i,
  input  logic [NET_W-1:0] raddr_i,
  output logic             rdata_o
);
  logic [DEPTH-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (we_i) en_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = en_q[raddr_i];

  // R8
  tbl_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> en_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/chf_hdr_filter.sv
`timescale 1ns/1ps
module chf_hdr_filter
  import chf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NET_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid_i,
  input  logic [15:0]       hdr_i,
  input  logic [ADDR_W-1:0] unit_addr_i,
  input  logic              cfg_we_i,
  input  logic [NET_W-1:0]  cfg_net_i,
  input  logic              cfg_en_i,
  output logic              out_valid_o,
  output logic              accept_o,
  output logic              crc_err_o,
  output logic [2:0]        cls_o
);
  logic [3:0]        crc_calc;
  route_e            route;
  cell_cls_e         cls_d;
  logic [ADDR_W-1:0] dest;
  logic [NET_W-1:0]  net;
  logic              net_en;
  logic              crc_ok;
  logic              route_hit;

  chf_crc4 #(.DATA_W(12), .CRC_W(4), .POLY(4'h3)) u_crc (
    .data_i (hdr_i[15:4]),
    .crc_o  (crc_calc)
  );

  chf_decode #(.ADDR_W(ADDR_W), .NET_W(NET_W)) u_dec (
    .body_i  (hdr_i[15:4]),
    .route_o (route),
    .cls_o   (cls_d),
    .dest_o  (dest),
    .net_o   (net)
  );

  chf_mcast_tbl #(.NET_W(NET_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_net_i),
    .wdata_i (cfg_en_i),
    .raddr_i (net),
    .rdata_o (net_en)
  );

  assign crc_ok = (crc_calc == hdr_i[3:0]);

  always_comb begin
    unique case (route)
      RT_BCAST:  route_hit = 1'b1;
      RT_MCAST:  route_hit = net_en;
      RT_SINGLE: route_hit = (dest == unit_addr_i);
      default:   route_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      crc_err_o   <= 1'b0;
      cls_o       <= 3'd0;
    end else begin
      out_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        accept_o  <= crc_ok && route_hit;
        crc_err_o <= !crc_ok;
        cls_o     <= cls_d;
      end else begin
        accept_o  <= 1'b0;
        crc_err_o <= 1'b0;
        cls_o     <= 3'd0;
      end
    end
  end

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid_i |=> out_valid_o);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid_i |=> !out_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> (!accept_o && !crc_err_o && cls_o == 3'd0));

  // R10
  crc_block_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> !accept_o);

  // R4
  bcast_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !crc_err_o && (cls_o == 3'd1 || cls_o == 3'd2)) |-> accept_o);

  // R7
  bad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && cls_o == 3'd0) |-> !accept_o);

  // R6
  sd_match_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid_i && hdr_i[15:14] == 2'b00 && hdr_i[11:4] != unit_addr_i) |=> !accept_o);
endmodule

// File: tb/chf_hdr_filter_bench.sv
`timescale 1ns/1ps
module chf_hdr_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic [15:0] hdr = '0;
  logic [7:0]  ua = 8'h00;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_net = '0;
  logic        cfg_en = 1'b0;
  logic        out_valid, accept, crc_err;
  logic [2:0]  cls;

  always #2.5 clk = ~clk;

  chf_hdr_filter u_chf_hdr_filter (
    .clk (clk), .rst (rst), .hdr_valid_i (hdr_valid), .hdr_i (hdr),
    .unit_addr_i (ua), .cfg_we_i (cfg_we), .cfg_net_i (cfg_net), .cfg_en_i (cfg_en),
    .out_valid_o (out_valid), .accept_o (accept), .crc_err_o (crc_err), .cls_o (cls)
  );

  typedef struct {
    logic       acc;
    logic       err;
    logic [2:0] cl;
    int         due;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   done = 0;
  logic tbl_m [64];

  always @(posedge clk) cyc <= cyc + 1;

  // Polynomial long division of {data, 0000} by 10011.
  function automatic logic [3:0] ref_crc(input logic [11:0] d);
    logic [15:0] v;
    v = {d, 4'b0000};
    for (int i = 15; i >= 4; i--)
      if (v[i]) v = v ^ (16'h0013 << (i - 4));
    return v[3:0];
  endfunction

  function automatic logic [15:0] mk(input logic [11:0] d);
    return {d, ref_crc(d)};
  endfunction

  function automatic exp_t model(input logic [15:0] h, input string tag);
    exp_t e;
    logic good, hit;
    good = (ref_crc(h[15:4]) == h[3:0]);
    if (h[15]) begin
      e.cl = h[14] ? 3'd4 : 3'd3;
      hit  = tbl_m[h[13:8]];
    end else if (h[14]) begin
      e.cl = h[13] ? 3'd2 : 3'd1;
      hit  = 1'b1;
    end else begin
      case (h[13:12])
        2'b00: e.cl = 3'd5;
        2'b01: e.cl = 3'd6;
        2'b10: e.cl = 3'd7;
        default: e.cl = 3'd0;
      endcase
      hit = (e.cl != 3'd0) && (h[11:4] == ua);
    end
    e.acc = good && hit;
    e.err = !good;
    e.tag = tag;
    e.due = 0;
    return e;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp_v, cyc);
    end
  endtask

  // Driver: present one header for one cycle, queue its expected result.
  task automatic send(input logic [15:0] h, input string tag);
    exp_t e;
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr = h;
    e = model(h, tag);
    e.due = cyc + 1;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdr_valid = 1'b0;
      hdr = '0;
    end
  endtask

  task automatic cfg(input logic [5:0] n, input logic v);
    @(negedge clk);
    hdr_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_net = n;
    cfg_en = v;
    @(negedge clk);
    cfg_we = 1'b0;
    tbl_m[n] = v;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (out_valid) begin
          if (q.size() == 0) begin
            check("R2 unexpected decision", 8'd1, 8'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " due cycle"}, 8'(cyc - e.due), 8'd0);
            check({e.tag, " accept/err/class"}, {3'b0, e.acc, e.err, e.cl} == {3'b0, e.acc, e.err, e.cl} ?
                  {3'b0, accept, crc_err, cls} : 8'hff, {3'b0, e.acc, e.err, e.cl});
          end
        end else begin
          if (accept || crc_err || cls != 3'd0)
            check("R2 outputs quiet while not valid", {3'b0, accept, crc_err, cls}, 8'd0);
          if (q.size() != 0 && q[0].due <= cyc) begin
            check({q[0].tag, " decision missing (R2)"}, 8'd0, 8'd1);
            void'(q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired (R2) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    hdr_valid = 1'b0;
    cfg_we = 1'b0;
    for (int i = 0; i < 64; i++) tbl_m[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tbl_m[i] = 1'b0;
    repeat (4) @(negedge clk);
    // R9: outputs cleared during reset
    check("R9 reset outputs", {4'b0, out_valid, accept, crc_err, |cls}, 8'd0);
    rst = 1'b0;
    ua = 8'h5A;
    @(negedge clk);
    check("R9 outputs after reset", {4'b0, out_valid, accept, crc_err, |cls}, 8'd0);

    // R4 R3: broadcast data and control
    send(mk({3'b010, 9'h000}), "R4 bc data");
    send(mk({3'b011, 9'h1FF}), "R4 bc ctrl");
    idle(2);
    // R1 R10: broadcast with damaged check field
    send(mk({3'b010, 9'h0A5}) ^ 16'h0001, "R10 bc bad crc");
    send(mk({3'b011, 9'h13C}) ^ 16'h0008, "R1 bc bad crc");
    idle(1);
    // R6 R3: single destination data/control/loopback
    send(mk({4'b0000, 8'h5A}), "R6 sd data match");
    send(mk({4'b0001, 8'h5A}), "R6 sd ctrl match");
    send(mk({4'b0010, 8'h5A}), "R6 sd loop match");
    send(mk({4'b0000, 8'h5B}), "R6 sd data mismatch");
    send(mk({4'b0010, 8'hA5}), "R6 sd loop mismatch");
    send(mk({4'b0001, 8'h5A}) ^ 16'h0004, "R10 sd match bad crc");
    // R7: malformed single-destination kind
    send(mk({4'b0011, 8'h5A}), "R7 sd kind 11");
    idle(2);
    // R5 R9: table empty after reset
    send(mk({2'b10, 6'd5, 4'h0}), "R5 mc net5 disabled");
    send(mk({2'b11, 6'd63, 4'h3}), "R5 mc net63 disabled");
    idle(1);
    // R8 R5: enable entries
    cfg(6'd5, 1'b1);
    cfg(6'd63, 1'b1);
    cfg(6'd0, 1'b1);
    send(mk({2'b10, 6'd5, 4'h0}), "R5 mc net5 enabled");
    send(mk({2'b11, 6'd6, 4'h0}), "R5 mc net6 disabled");
    send(mk({2'b11, 6'd63, 4'hF}), "R5 mc net63 enabled");
    send(mk({2'b10, 6'd0, 4'h9}), "R5 mc net0 enabled");
    send(mk({2'b10, 6'd5, 4'h0}) ^ 16'h0002, "R10 mc enabled bad crc");
    idle(1);
    // R8: clear an entry
    cfg(6'd5, 1'b0);
    send(mk({2'b10, 6'd5, 4'h0}), "R8 mc net5 cleared");
    idle(2);
    // R9: reset clears the table
    cfg(6'd9, 1'b1);
    send(mk({2'b11, 6'd9, 4'h0}), "R8 mc net9 set");
    idle(2);
    do_reset();
    @(negedge clk);
    send(mk({2'b11, 6'd9, 4'h0}), "R9 mc net9 after reset");
    idle(2);
    // R1 R2: every body value with a good check field, back to back
    cfg(6'd17, 1'b1);
    cfg(6'd42, 1'b1);
    ua = 8'hC3;
    for (int d = 0; d < 4096; d++) send(mk(12'(d)), "R1 good crc sweep");
    idle(2);
    // R1: single-bit damage in the check field
    for (int d = 0; d < 4096; d += 7) send(mk(12'(d)) ^ (16'h0001 << (d % 4)), "R1 bad crc sweep");
    // R1: damage in the body bits
    for (int d = 0; d < 4096; d += 13) send(mk(12'(d)) ^ (16'h0010 << (d % 12)), "R1 body damage sweep");
    idle(4);
    check("R2 queue drained", 8'(q.size()), 8'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule